// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block brings the analog front end of a storage-interface PHY up and down in a fixed, timed order. It drives two control lines toward the PHY: a power enable (active high; low means powered down) and a DLL enable. It watches two status lines from the PHY: calibration complete and DLL locked. Both status lines are taken to be synchronous to the block clock.

A power-on request first drives both controls low and holds them there long enough for the calibration logic inside the PHY to initialise. It then raises the power enable and waits for calibration to settle before checking the calibration status. After that it raises the DLL enable and waits for the DLL to lock before checking the lock status. A failed check stops the sequence, drops both controls and reports a cause code. A power-off request drops both controls at once. A request for the power state already held completes at once and changes nothing. A `CLK_HZ` parameter turns the three waits (3 µs, 5 µs and 11 µs by default) into whole cycle counts.

Top module: `phy_pwr_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pwr_up_o`, `dll_en_o`, `powered_on_o`, `busy_o`, `done_o` and `err_o` are 0 and `err_cause_o` is 0.
- R2: An accepted power-on request from the off state drives both controls low. `pwr_up_o` rises exactly N_SET clock edges after the edge that accepts the request.
- R3: The calibration input is sampled on the edge N_CAL cycles after `pwr_up_o` rises. If it is 0, then on that edge `err_o` is set with cause 1, both controls drop, `done_o` pulses and `powered_on_o` stays 0.
- R4: If calibration passes, `dll_en_o` rises on that same edge. The DLL lock input is sampled N_DLL cycles later. If it is 0, `err_o` is set with cause 2, both controls drop, `done_o` pulses and `powered_on_o` stays 0.
- R5: If the lock check passes, `done_o` pulses, `busy_o` falls, `powered_on_o` becomes 1 and both controls stay high.
- R6: A power-off request accepted while on drops both controls and `powered_on_o` on the accepting edge, and `done_o` pulses on that same edge.
- R7: A request for the state already held gives a one-cycle `done_o` on the accepting edge. It leaves both controls and `powered_on_o` unchanged and never raises `busy_o`.
- R8: Requests that arrive while `busy_o` is high are ignored, including one that arrives on the cycle in which a sequence completes.
- R9: When `req_on` and `req_off` are both high in the same idle cycle, the off request wins.
- R10: Any accepted request clears `err_o` and sets `err_cause_o` to 0 on the accepting edge.
- R11: `busy_o` is high from the accepting edge of a power-on sequence until its completion edge. `done_o` is a single-cycle pulse and is never high together with `busy_o`. `dll_en_o` is never high while `pwr_up_o` is low.
- R12: N_SET, N_CAL and N_DLL are each the matching delay in nanoseconds times `CLK_HZ`, divided by 10^9 and rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_on | input | 1 | Power-on request pulse |
| req_off | input | 1 | Power-off request pulse |
| cal_ok_i | input | 1 | Calibration complete status from the PHY |
| dll_lock_i | input | 1 | DLL locked status from the PHY |
| pwr_up_o | output | 1 | PHY power enable (low = powered down) |
| dll_en_o | output | 1 | PHY DLL enable |
| busy_o | output | 1 | Power-on sequence in progress |
| done_o | output | 1 | One-cycle pulse when a request completes |
| err_o | output | 1 | Last sequence stopped on a failed check |
| err_cause_o | output | 2 | 0 none, 1 calibration timeout, 2 DLL timeout |
| powered_on_o | output | 1 | Current settled power state |

## Verification
Two events can land on the same clock edge. One is a new request arriving on the edge where a running sequence finishes. The other is an on request and an off request arriving together. The bench drives `req_off` on exactly the cycle whose edge samples the DLL lock. The sequence must still end powered on, with a single done pulse, which shows the late request was dropped. It also raises both requests in one idle cycle, once while on and once while off. In both cases the outcome must match an off request alone. The calibration and lock inputs come from models whose rise delays are swept one cycle either side of each sample point, so every pass and fail result at the boundary is predicted from the cycle counts.

// File: rtl/phy_pwr_pkg.sv
// Package: shared types and delay arithmetic for the PHY power sequencer.
// Assumes delays are given in nanoseconds and the clock in hertz.
package phy_pwr_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_CALCHK = 2'd2,
        SEQ_DLLCHK = 2'd3
    } seq_state_t;

    // Fault codes reported on err_cause_o
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_CAL  = 2'd1,
        CAUSE_DLL  = 2'd2
    } fault_t;

    // Converts a delay in ns to clock cycles, rounding up
    function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                     input longint unsigned hz);
        return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

    // Largest of three values
    function automatic longint unsigned max3(input longint unsigned a,
                                             input longint unsigned b,
                                             input longint unsigned c);
        longint unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Reload value for a down-counter that expires after n cycles
    function automatic longint unsigned reload_of(input longint unsigned n);
        return (n > 0) ? n - 1 : 0;
    endfunction

endpackage

// File: rtl/pwr_wait_timer.sv
// Module: down-counting wait timer.
// Loading value v makes expired_o go high after v further cycles, so a load
// of N-1 expires on the N-th edge after the load edge. It holds at zero.
module pwr_wait_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_req_arbiter.sv
// Module: request decode for the sequencer.
// Takes requests only while idle; off beats on when both are raised.
// Classifies each accepted request as a start, a drop or a no-op.
module pwr_req_arbiter (
    input  logic idle_i,
    input  logic powered_i,
    input  logic req_on_i,
    input  logic req_off_i,
    output logic accept_o,
    output logic start_seq_o,
    output logic drop_o,
    output logic nop_o
);
    logic off_sel;
    logic on_sel;

    // Priority and state-based classification of the request
    always_comb begin
        off_sel     = idle_i & req_off_i;
        on_sel      = idle_i & req_on_i & ~req_off_i;
        accept_o    = off_sel | on_sel;
        start_seq_o = on_sel & ~powered_i;
        drop_o      = off_sel & powered_i;
        nop_o       = (on_sel & powered_i) | (off_sel & ~powered_i);
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
// Module: power sequencing state machine.
// Walks settle -> calibration check -> DLL check, loading the wait timer
// at each phase and checking status when it expires. All outputs are
// registered. Status inputs are assumed synchronous to clk.
module pwr_seq_fsm
    import phy_pwr_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int SET_LD = 749,
    parameter int CAL_LD = 1249,
    parameter int DLL_LD = 2749
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             start_seq_i,
    input  logic             drop_i,
    input  logic             nop_i,
    input  logic             expired_i,
    input  logic             cal_ok_i,
    input  logic             dll_lock_i,
    output logic             idle_o,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             pwr_up_o,
    output logic             dll_en_o,
    output logic             powered_o,
    output logic             done_o,
    output logic             err_o,
    output logic [1:0]       cause_o
);
    seq_state_t state_q;
    fault_t     cause_q;

    // Timer reload selection for the phase being entered
    always_comb begin
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                tmr_load_o = start_seq_i;
                tmr_val_o  = CNT_W'(SET_LD);
            end
            SEQ_SETTLE: begin
                tmr_load_o = expired_i;
                tmr_val_o  = CNT_W'(CAL_LD);
            end
            SEQ_CALCHK: begin
                tmr_load_o = expired_i & cal_ok_i;
                tmr_val_o  = CNT_W'(DLL_LD);
            end
            default: begin
                tmr_load_o = 1'b0;
                tmr_val_o  = '0;
            end
        endcase
    end

    // Phase transitions, control outputs and result reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            pwr_up_o  <= 1'b0;
            dll_en_o  <= 1'b0;
            powered_o <= 1'b0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
            cause_q   <= CAUSE_NONE;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept_i) begin
                        err_o   <= 1'b0;
                        cause_q <= CAUSE_NONE;
                    end
                    if (drop_i) begin
                        pwr_up_o  <= 1'b0;
                        dll_en_o  <= 1'b0;
                        powered_o <= 1'b0;
                        done_o    <= 1'b1;
                    end else if (nop_i) begin
                        done_o <= 1'b1;
                    end else if (start_seq_i) begin
                        pwr_up_o <= 1'b0;
                        dll_en_o <= 1'b0;
                        state_q  <= SEQ_SETTLE;
                    end
                end
                SEQ_SETTLE: begin
                    if (expired_i) begin
                        pwr_up_o <= 1'b1;
                        state_q  <= SEQ_CALCHK;
                    end
                end
                SEQ_CALCHK: begin
                    if (expired_i) begin
                        if (cal_ok_i) begin
                            dll_en_o <= 1'b1;
                            state_q  <= SEQ_DLLCHK;
                        end else begin
                            pwr_up_o <= 1'b0;
                            dll_en_o <= 1'b0;
                            err_o    <= 1'b1;
                            cause_q  <= CAUSE_CAL;
                            done_o   <= 1'b1;
                            state_q  <= SEQ_IDLE;
                        end
                    end
                end
                SEQ_DLLCHK: begin
                    if (expired_i) begin
                        done_o  <= 1'b1;
                        state_q <= SEQ_IDLE;
                        if (dll_lock_i) begin
                            powered_o <= 1'b1;
                        end else begin
                            pwr_up_o <= 1'b0;
                            dll_en_o <= 1'b0;
                            err_o    <= 1'b1;
                            cause_q  <= CAUSE_DLL;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign idle_o  = (state_q == SEQ_IDLE);
    assign cause_o = cause_q;
endmodule

// File: rtl/phy_pwr_seq.sv
// Module: PHY power-up sequencer top.
// Derives the three wait lengths from CLK_HZ and the ns parameters
// (rounded up), sizes the shared timer for the longest, and wires the
// request decoder, state machine and timer together.
module phy_pwr_seq
    import phy_pwr_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 250_000_000,
    parameter int unsigned     SETTLE_NS = 3000,
    parameter int unsigned     CAL_NS    = 5000,
    parameter int unsigned     DLL_NS    = 11000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_on,
    input  logic       req_off,
    input  logic       cal_ok_i,
    input  logic       dll_lock_i,
    output logic       pwr_up_o,
    output logic       dll_en_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] err_cause_o,
    output logic       powered_on_o
);
    localparam longint unsigned N_SET = ns_to_cycles(64'(SETTLE_NS), CLK_HZ);
    localparam longint unsigned N_CAL = ns_to_cycles(64'(CAL_NS), CLK_HZ);
    localparam longint unsigned N_DLL = ns_to_cycles(64'(DLL_NS), CLK_HZ);
    localparam longint unsigned N_MAX = max3(N_SET, N_CAL, N_DLL);
    localparam int CNT_W  = (N_MAX < 2) ? 1 : $clog2(N_MAX);
    localparam int SET_LD = int'(reload_of(N_SET));
    localparam int CAL_LD = int'(reload_of(N_CAL));
    localparam int DLL_LD = int'(reload_of(N_DLL));

    logic             idle;
    logic             accept;
    logic             start_seq;
    logic             drop;
    logic             nop;
    logic             expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;

    pwr_req_arbiter u_arb (
        .idle_i      (idle),
        .powered_i   (powered_on_o),
        .req_on_i    (req_on),
        .req_off_i   (req_off),
        .accept_o    (accept),
        .start_seq_o (start_seq),
        .drop_o      (drop),
        .nop_o       (nop)
    );

    pwr_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (expired)
    );

    pwr_seq_fsm #(
        .CNT_W  (CNT_W),
        .SET_LD (SET_LD),
        .CAL_LD (CAL_LD),
        .DLL_LD (DLL_LD)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .start_seq_i (start_seq),
        .drop_i      (drop),
        .nop_i       (nop),
        .expired_i   (expired),
        .cal_ok_i    (cal_ok_i),
        .dll_lock_i  (dll_lock_i),
        .idle_o      (idle),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .pwr_up_o    (pwr_up_o),
        .dll_en_o    (dll_en_o),
        .powered_o   (powered_on_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .cause_o     (err_cause_o)
    );

    // Busy whenever the state machine is away from idle
    assign busy_o = ~idle;
endmodule

// File: rtl/phy_pwr_seq_chk.sv
// Checker: temporal properties of the sequencer, seen at its ports.
// Attached to every phy_pwr_seq instance by the bind below.
module phy_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_up_o,
    input logic       dll_en_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic [1:0] err_cause_o,
    input logic       powered_on_o
);
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_dll_after_pwr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en_o |-> pwr_up_o);

    p_dll_rise_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en_o) |-> $past(pwr_up_o));

    p_fault_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!pwr_up_o && !dll_en_o && !powered_on_o && done_o));

    p_cause_coded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_cause_o == 2'd1 || err_cause_o == 2'd2));

    p_cause_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (err_cause_o == 2'd0));

    p_on_controls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        powered_on_o |-> (pwr_up_o && dll_en_o && !busy_o));

    p_on_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_on_o) |-> done_o);
endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_up_o     (pwr_up_o),
    .dll_en_o     (dll_en_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_cause_o  (err_cause_o),
    .powered_on_o (powered_on_o)
);

// File: tb/sim_phy_pwr_seq.sv
// Bench: sweeps the calibration and lock delays across each sample point
// and drives colliding and same-state requests. Every wait length comes
// from the delay arithmetic alone.
module sim_phy_pwr_seq;
    localparam longint unsigned HZ    = 250_000_000;
    localparam longint unsigned N_SET = (64'd3000  * HZ + 64'd999_999_999) / 64'd1_000_000_000;
    localparam longint unsigned N_CAL = (64'd5000  * HZ + 64'd999_999_999) / 64'd1_000_000_000;
    localparam longint unsigned N_DLL = (64'd11000 * HZ + 64'd999_999_999) / 64'd1_000_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_on = 1'b0;
    logic       req_off = 1'b0;
    logic       cal_ok_i = 1'b0;
    logic       dll_lock_i = 1'b0;
    logic       pwr_up_o, dll_en_o, busy_o, done_o, err_o, powered_on_o;
    logic [1:0] err_cause_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int cal_d = 0;
    int dll_d = 0;
    int cal_cnt = 0;
    int dll_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    phy_pwr_seq #(.CLK_HZ(HZ)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_on       (req_on),
        .req_off      (req_off),
        .cal_ok_i     (cal_ok_i),
        .dll_lock_i   (dll_lock_i),
        .pwr_up_o     (pwr_up_o),
        .dll_en_o     (dll_en_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .err_cause_o  (err_cause_o),
        .powered_on_o (powered_on_o)
    );

    // PHY model: status rises a set number of cycles after its enable
    always @(negedge clk) begin
        cal_cnt    = pwr_up_o ? cal_cnt + 1 : 0;
        dll_cnt    = dll_en_o ? dll_cnt + 1 : 0;
        cal_ok_i   = pwr_up_o && (cal_cnt >= cal_d);
        dll_lock_i = dll_en_o && (dll_cnt >= dll_d);
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=%0d expected below=%0d", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One-cycle request; returns at the negedge after the accepting edge
    task automatic pulse(input logic on, input logic off);
        @(negedge clk);
        req_on  = on;
        req_off = off;
        @(negedge clk);
        req_on  = 1'b0;
        req_off = 1'b0;
    endtask

    task automatic run_on(input int cd, input int dd, input bit ign, input bit collide);
        int  c;
        bit  ok_cal;
        bit  ok_dll;
        cal_d  = cd;
        dll_d  = dd;
        ok_cal = (cd <= int'(N_CAL));
        ok_dll = (dd <= int'(N_DLL));
        pulse(1'b1, 1'b0);
        chk("R10 err cleared at accept", err_o, 0);
        chk("R10 cause cleared at accept", err_cause_o, 0);
        chk("R11 busy after accept", busy_o, 1);
        chk("R2 power low in settle", pwr_up_o, 0);
        c = 1;
        while (!pwr_up_o && c < 20000) begin
            @(negedge clk);
            c++;
            req_off = ign && (c == 3);
        end
        req_off = 1'b0;
        chk("R2/R12 settle length", c, N_SET + 1);
        c = 1;
        while (!dll_en_o && !err_o && c < 20000) begin
            @(negedge clk);
            c++;
            req_on = ign && (c == 5);
        end
        req_on = 1'b0;
        chk("R3/R12 calibration sample point", c, N_CAL + 1);
        if (!ok_cal) begin
            chk("R3 err flag", err_o, 1);
            chk("R3 cause code", err_cause_o, 1);
            chk("R3 power dropped", pwr_up_o, 0);
            chk("R3 dll low", dll_en_o, 0);
            chk("R3 state stays off", powered_on_o, 0);
            chk("R3 done pulse", done_o, 1);
            @(negedge clk);
            chk("R11 done single cycle", done_o, 0);
            return;
        end
        chk("R4 dll enabled", dll_en_o, 1);
        chk("R4 power held", pwr_up_o, 1);
        chk("R11 busy during dll wait", busy_o, 1);
        c = 1;
        while (!done_o && c < 20000) begin
            @(negedge clk);
            c++;
            req_off = collide && (c == int'(N_DLL));
        end
        req_off = 1'b0;
        chk("R4/R12 lock sample point", c, N_DLL + 1);
        chk("R11 busy low at done", busy_o, 0);
        if (ok_dll) begin
            chk("R5 powered on", powered_on_o, 1);
            chk("R5 power high", pwr_up_o, 1);
            chk("R5 dll high", dll_en_o, 1);
            chk("R5 no error", err_o, 0);
        end else begin
            chk("R4 err flag", err_o, 1);
            chk("R4 cause code", err_cause_o, 2);
            chk("R4 power dropped", pwr_up_o, 0);
            chk("R4 dll dropped", dll_en_o, 0);
            chk("R4 state stays off", powered_on_o, 0);
        end
        @(negedge clk);
        chk("R11 done single cycle", done_o, 0);
        if (collide && ok_dll) begin
            chk("R8 request at completion ignored", powered_on_o, 1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 power in reset", pwr_up_o, 0);
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 powered in reset", powered_on_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dll after reset", dll_en_o, 0);
        chk("R1 done after reset", done_o, 0);
        chk("R1 err after reset", err_o, 0);
        chk("R1 cause after reset", err_cause_o, 0);

        pulse(1'b0, 1'b1);
        chk("R7 off-when-off done", done_o, 1);
        chk("R7 off-when-off not busy", busy_o, 0);
        chk("R7 off-when-off power", pwr_up_o, 0);

        for (int cd = int'(N_CAL) - 1; cd <= int'(N_CAL) + 1; cd++) begin
            for (int dd = int'(N_DLL) - 1; dd <= int'(N_DLL) + 1; dd++) begin
                run_on(cd, dd, 1'b0, 1'b0);
                if (powered_on_o) begin
                    pulse(1'b0, 1'b1);
                    chk("R6 power dropped", pwr_up_o, 0);
                    chk("R6 dll dropped", dll_en_o, 0);
                    chk("R6 state off", powered_on_o, 0);
                    chk("R6 done pulse", done_o, 1);
                end
            end
        end

        run_on(2, 2, 1'b1, 1'b1);
        chk("R8 busy requests ignored", powered_on_o, 1);

        pulse(1'b1, 1'b0);
        chk("R7 on-when-on done", done_o, 1);
        chk("R7 on-when-on busy", busy_o, 0);
        chk("R7 on-when-on power", pwr_up_o, 1);
        chk("R7 on-when-on dll", dll_en_o, 1);

        pulse(1'b1, 1'b1);
        chk("R9 off wins while on", powered_on_o, 0);
        chk("R9 power dropped", pwr_up_o, 0);
        chk("R9 done pulse", done_o, 1);

        pulse(1'b1, 1'b1);
        chk("R9 off wins while off", busy_o, 0);
        chk("R9 done while off", done_o, 1);
        @(negedge clk);
        chk("R9 no sequence started", busy_o, 0);
        chk("R9 power stays low", pwr_up_o, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule